// File: doc/BRIEF.md
# Sprite Attribute Cache Write Snooper

This block sits beside the path that carries writes into video memory and keeps a private copy of the leading half of every sprite attribute entry. Each entry in the sprite table is eight bytes long. The cache keeps only its first four bytes, so a 512-byte cache shadows a 1024-byte window of video memory. That window starts at a table base address supplied from a control register. The sprite engine reads cached bytes through a synchronous read port. It never has to arbitrate for the main memory to get this data.

The cache fills only by watching writes. A write is copied in when the extended display mode is on, the write falls inside the window, and address bit 2 is clear. The byte offset from the base is folded into a compact index that drops offset bit 2. Word writes fill two neighbouring cache bytes. Single-byte writes and the completing half of a split byte-wise transfer fill one cache byte.

Top module: `sat_snoop_cache`

## Requirements
- R1: While `mode5_en` is 0, or while `wr_en` is 0, no cache byte changes.
- R2: A write whose effective byte address has bit 2 set leaves the cache unchanged.
- R3: A write is captured only if its effective address A satisfies base <= A < base + 2*CACHE_BYTES. The base is the value on `sat_base` in the cycle of the write.
- R4: The cache index of a captured write is ((A - base) & 3) | (((A - base) >> 1) & (CACHE_BYTES - 4)).
- R5: When `wr_kind` = 2'b00 (word), `wr_data[15:8]` is stored at the index and `wr_data[7:0]` at the index with bit 0 inverted.
- R6: When `wr_kind` = 2'b01 (single byte), `wr_data[7:0]` is stored at the index and no other cache byte changes.
- R7: When `wr_kind` = 2'b10 (first half of a split transfer), the cache is unchanged.
- R8: When `wr_kind` = 2'b11 (completing half of a split transfer), the effective address is `wr_addr` with bit 0 inverted. One byte is stored there: `wr_data[15:8]` when `wr_hi_lane` is 1, and `wr_data[7:0]` otherwise.
- R9: `rd_data` shows the cache byte at `rd_idx` one clock after the index is presented. When a write to that index happens in the same cycle, `rd_data` shows the newly written byte.
- R10: While `rst_n` is low, `rd_data` is 0. Cache contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| mode5_en | input | 1 | Extended display mode enable; snooping only when 1 |
| sat_base | input | ADDR_W | Sprite table base byte address, word aligned |
| wr_en | input | 1 | Video memory write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 16 | Write data word |
| wr_kind | input | 2 | 00 word, 01 byte, 10 split first half, 11 split completing half |
| wr_hi_lane | input | 1 | For a completing half: 1 selects the upper data byte |
| rd_idx | input | $clog2(CACHE_BYTES) | Cache read index |
| rd_data | output | 8 | Cached byte, registered |

## Verification
A write updates the cache at the rising edge where `wr_en` is sampled. A read of that index presented in the following cycle returns the new byte. A read presented in the same cycle also returns it, through the write-through path. `rd_data` always lags `rd_idx` by exactly one edge. The bench therefore changes inputs on the falling edge and reads `rd_data` on the next falling edge, which is one rising edge later. The cache contents are fully swept after each group of writes, and the expected value of every byte comes from an arithmetic model of the index and lane rules.

// File: rtl/sat_snoop_pkg.sv
package sat_snoop_pkg;
   typedef enum logic [1:0] {
      WK_WORD    = 2'b00,
      WK_BYTE    = 2'b01,
      WK_SPLIT_A = 2'b10,
      WK_SPLIT_B = 2'b11
   } wr_kind_e;
endpackage

// File: rtl/sat_snoop_decode.sv
// Window check and index folding for one snooped write.
module sat_snoop_decode
   import sat_snoop_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int CACHE_BYTES = 512
) (
   input  logic                             wr_en,
   input  logic                             mode5_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  wr_kind_e                         wr_kind,
   input  logic [ADDR_W-1:0]                sat_base,
   output logic                             hit,
   output logic [$clog2(CACHE_BYTES)-1:0]   idx
);
   localparam int IDX_W     = $clog2(CACHE_BYTES);
   localparam int WIN_BYTES = 2 * CACHE_BYTES;
   localparam logic [ADDR_W:0] WIN  = (ADDR_W+1)'(WIN_BYTES);
   localparam logic [IDX_W:0]  MASK = (IDX_W+1)'(CACHE_BYTES - 4);
   localparam logic [IDX_W:0]  LOW2 = (IDX_W+1)'(3);

   logic [ADDR_W-1:0] eff;
   logic [ADDR_W:0]   win_lo, win_hi, eff_x;
   logic              in_win;
   logic [IDX_W:0]    off_lo;

   // completing half of a split transfer lands on the partner byte
   assign eff    = (wr_kind == WK_SPLIT_B) ? (wr_addr ^ ADDR_W'(1)) : wr_addr;
   assign eff_x  = {1'b0, eff};
   assign win_lo = {1'b0, sat_base};
   assign win_hi = win_lo + WIN;
   assign in_win = (eff_x >= win_lo) && (eff_x < win_hi);
   assign off_lo = eff[IDX_W:0] - sat_base[IDX_W:0];
   assign idx    = IDX_W'(((off_lo >> 1) & MASK) | (off_lo & LOW2));
   assign hit    = wr_en && mode5_en && !eff[2] && in_win
                   && (wr_kind != WK_SPLIT_A);
endmodule

// File: rtl/sat_snoop_lanes.sv
// Turns a hit plus index into per-lane byte enables for a pair-organised store.
module sat_snoop_lanes
   import sat_snoop_pkg::*;
#(
   parameter int IDX_W = 9
) (
   input  logic              hit,
   input  logic [IDX_W-1:0]  idx,
   input  logic [15:0]       wr_data,
   input  wr_kind_e          wr_kind,
   input  logic              wr_hi_lane,
   output logic [IDX_W-2:0]  pair,
   output logic [1:0]        be,
   output logic [1:0][7:0]   lane_dat
);
   logic [7:0] one_byte;

   assign one_byte = (wr_kind == WK_SPLIT_B && wr_hi_lane) ? wr_data[15:8]
                                                            : wr_data[7:0];
   assign pair = idx[IDX_W-1:1];

   always_comb begin
      be       = '0;
      lane_dat = '0;
      if (hit) begin
         if (wr_kind == WK_WORD) begin
            be                  = 2'b11;
            lane_dat[idx[0]]    = wr_data[15:8];
            lane_dat[!idx[0]]   = wr_data[7:0];
         end else begin
            be[idx[0]]       = 1'b1;
            lane_dat[idx[0]] = one_byte;
         end
      end
   end
endmodule

// File: rtl/sat_snoop_store.sv
// Two byte lanes of storage with a registered, write-through read port.
module sat_snoop_store #(
   parameter int IDX_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-2:0]  pair,
   input  logic [1:0]        be,
   input  logic [1:0][7:0]   lane_dat,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_data
);
   localparam int PAIRS = 1 << (IDX_W - 1);

   logic [1:0][7:0] rd_lane;
   logic [1:0]      byp;

   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [7:0] mem [PAIRS];
      always_ff @(posedge clk) begin
         if (be[g]) mem[pair] <= lane_dat[g];
      end
      assign rd_lane[g] = mem[rd_idx[IDX_W-1:1]];
      assign byp[g]     = be[g] && (pair == rd_idx[IDX_W-1:1]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                rd_data <= '0;
      else if (byp[rd_idx[0]])   rd_data <= lane_dat[rd_idx[0]];
      else                       rd_data <= rd_lane[rd_idx[0]];
   end
endmodule

// File: rtl/sat_snoop_cache.sv
module sat_snoop_cache
   import sat_snoop_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int CACHE_BYTES = 512
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            mode5_en,
   input  logic [ADDR_W-1:0]               sat_base,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [15:0]                     wr_data,
   input  logic [1:0]                      wr_kind,
   input  logic                            wr_hi_lane,
   input  logic [$clog2(CACHE_BYTES)-1:0]  rd_idx,
   output logic [7:0]                      rd_data
);
   localparam int IDX_W = $clog2(CACHE_BYTES);

   if (CACHE_BYTES < 8 || (CACHE_BYTES & (CACHE_BYTES - 1)) != 0) begin : g_bad_size
      $error("CACHE_BYTES must be a power of two, at least 8");
   end
   if (ADDR_W <= IDX_W + 1) begin : g_bad_addr
      $error("ADDR_W must cover twice the cache size");
   end

   wr_kind_e         kind;
   logic             hit;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-2:0] wr_pair;
   logic [1:0]       wr_be;
   logic [1:0][7:0]  wr_lane;

   assign kind = wr_kind_e'(wr_kind);

   sat_snoop_decode #(.ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES)) u_dec (
      .wr_en(wr_en), .mode5_en(mode5_en), .wr_addr(wr_addr),
      .wr_kind(kind), .sat_base(sat_base), .hit(hit), .idx(idx)
   );

   sat_snoop_lanes #(.IDX_W(IDX_W)) u_lanes (
      .hit(hit), .idx(idx), .wr_data(wr_data), .wr_kind(kind),
      .wr_hi_lane(wr_hi_lane), .pair(wr_pair), .be(wr_be), .lane_dat(wr_lane)
   );

   sat_snoop_store #(.IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .pair(wr_pair), .be(wr_be),
      .lane_dat(wr_lane), .rd_idx(rd_idx), .rd_data(rd_data)
   );
endmodule

// File: rtl/sat_snoop_chk.sv
module sat_snoop_chk #(
   parameter int ADDR_W      = 16,
   parameter int CACHE_BYTES = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode5_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ADDR_W-1:0] sat_base,
   input logic [1:0]        wr_kind,
   input logic [1:0]        be
);
   localparam logic [ADDR_W:0] WIN = (ADDR_W+1)'(2 * CACHE_BYTES);

   // R1: no store activity without mode enable or strobe
   a_r1_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode5_en || !wr_en) |-> (be == 2'b00));
   // R2: upper half of each entry never cached
   a_r2_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
      wr_addr[2] |-> (be == 2'b00));
   // R3: writes below the base are ignored
   a_r3_below_base: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, wr_addr} < {1'b0, sat_base}) |-> (be == 2'b00));
   // R3: writes at or beyond the window top are ignored
   a_r3_above_top: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, wr_addr} >= ({1'b0, sat_base} + WIN)) |-> (be == 2'b00));
   // R5: a captured word fills both lanes of a pair
   a_r5_word_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == 2'b00 && be != 2'b00) |-> (be == 2'b11));
   // R6 and R8: byte-sized writes touch at most one lane
   a_r6_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind != 2'b00) |-> ($countones(be) <= 1));
   // R7: first half of a split transfer is never captured
   a_r7_split_first: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == 2'b10) |-> (be == 2'b00));
endmodule

bind sat_snoop_cache sat_snoop_chk #(.ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode5_en(mode5_en), .wr_en(wr_en),
   .wr_addr(wr_addr), .sat_base(sat_base), .wr_kind(wr_kind), .be(wr_be)
);

// File: tb/sim_sat_snoop_cache.sv
`timescale 1ns/1ps
module sim_sat_snoop_cache;
   localparam int CB = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode5_en = 1'b0;
   logic [15:0] sat_base = 16'h1000;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  wr_kind = 2'b00;
   logic        wr_hi_lane = 1'b0;
   logic [8:0]  rd_idx = '0;
   logic [7:0]  rd_data;

   logic [7:0]  mdl_mem [CB];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   sat_snoop_cache u0 (
      .clk(clk), .rst_n(rst_n), .mode5_en(mode5_en), .sat_base(sat_base),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_kind(wr_kind),
      .wr_hi_lane(wr_hi_lane), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] want);
      n_chk++;
      if (got !== want) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h (rd_idx %0d)", req, got, want, rd_idx);
      end
   endtask

   // arithmetic model of the snoop rules
   function automatic int mdl_index(input int a);
      int off;
      off = a - int'(sat_base);
      return (off & 3) | ((off >> 1) & (CB - 4));
   endfunction

   task automatic mdl_apply(input logic [15:0] a, input logic [15:0] d,
                            input logic [1:0] k, input logic hl);
      int e, ix;
      e = (k == 2'b11) ? int'(a ^ 16'h1) : int'(a);
      if (!mode5_en || k == 2'b10) return;                   // R1, R7
      if (e[2]) return;                                       // R2
      if (e < int'(sat_base) || e >= int'(sat_base) + 2*CB) return; // R3
      ix = mdl_index(e);                                      // R4
      if (k == 2'b00) begin                                   // R5
         mdl_mem[ix]     = d[15:8];
         mdl_mem[ix ^ 1] = d[7:0];
      end else if (k == 2'b01) begin                          // R6
         mdl_mem[ix] = d[7:0];
      end else begin                                          // R8
         mdl_mem[ix] = hl ? d[15:8] : d[7:0];
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d,
                     input logic [1:0] k, input logic hl);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_kind = k; wr_hi_lane = hl;
      @(negedge clk);
      wr_en = 1'b0;
      mdl_apply(a, d, k, hl);
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < CB; i++) begin
         rd_idx = 9'(i);
         @(negedge clk);
         chk(req, rd_data, mdl_mem[i]);
      end
   endtask

   initial begin
      repeat (120000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset read", rd_data, 8'h00);
      rst_n = 1'b1;
      mode5_en = 1'b1;
      @(negedge clk);

      // fill every entry with word writes; upper halves also written (R2)
      for (int e = 0; e < 128; e++) begin
         for (int h = 0; h < 2; h++) begin
            wr(16'(16'h1000 + 8*e + 2*h), {8'(e ^ 8'hA5 ^ h), 8'(e + 64*h + 3)}, 2'b00, 1'b0);
            wr(16'(16'h1000 + 8*e + 4 + 2*h), 16'hDEAD, 2'b00, 1'b0);
         end
      end
      sweep("R5 word fill and R2 upper half");

      // mode off: nothing captured
      mode5_en = 1'b0;
      for (int e = 0; e < 128; e++) wr(16'(16'h1000 + 8*e), 16'h1111, 2'b00, 1'b0);
      wr(16'h1001, 16'h2222, 2'b01, 1'b0);
      sweep("R1 mode off");
      mode5_en = 1'b1;

      // outside the window
      wr(16'h0FFE, 16'h3333, 2'b00, 1'b0);
      wr(16'h0FF8, 16'h3434, 2'b00, 1'b0);
      wr(16'h0FFF, 16'h3535, 2'b11, 1'b1);
      wr(16'h1400, 16'h3636, 2'b00, 1'b0);
      wr(16'h1401, 16'h3737, 2'b01, 1'b0);
      wr(16'h1402, 16'h3838, 2'b00, 1'b0);
      sweep("R3 outside window");

      // first halves of split transfers are ignored
      for (int e = 0; e < 64; e++) wr(16'(16'h1000 + 8*e + (e % 4)), 16'h4444, 2'b10, e[0]);
      sweep("R7 split first half");

      // single-byte writes at all four lane offsets
      for (int e = 0; e < 64; e++) wr(16'(16'h1000 + 8*e + (e % 4)), {8'hEE, 8'(e + 8'h80)}, 2'b01, 1'b0);
      sweep("R6 byte write");

      // completing halves, both lanes
      for (int e = 0; e < 64; e++)
         wr(16'(16'h1000 + 8*(e + 64) + (e % 4)), {8'(8'hC0 + e), 8'(8'h30 + e)}, 2'b11, e[0]);
      sweep("R8 split completing half");

      // word-aligned base that is not entry-aligned; sweep across both edges
      sat_base = 16'h2006;
      for (int a = 16'h2002; a < 16'h2006 + 2*CB + 6; a += 2)
         wr(16'(a), 16'(a * 3 + 16'h5A00), 2'b00, 1'b0);
      sweep("R3 R4 shifted base");

      // read and write to the same index in one cycle
      for (int e = 0; e < 16; e++) begin
         int ix;
         ix = mdl_index(16'h2008 + 8*e + 2*(e % 2));
         wr_en = 1'b1; wr_addr = 16'(16'h2008 + 8*e + 2*(e % 2));
         wr_data = {8'(e + 8'h10), 8'(e + 8'h90)}; wr_kind = 2'b00; wr_hi_lane = 1'b0;
         rd_idx = 9'(ix ^ (e % 2 == 0 ? 0 : 1));
         @(negedge clk);
         wr_en = 1'b0;
         mdl_apply(wr_addr, wr_data, 2'b00, 1'b0);
         chk("R9 write-through read", rd_data, mdl_mem[rd_idx]);
      end
      sweep("R9 read latency");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule